// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Address-Filtered Reception

This block is a full-duplex asynchronous serial port for attachment to a processor's byte-wide register bus. A transmit holding byte is moved into a shift register and sent as a frame of one low start bit, eight data bits (least significant first), an optional ninth bit and one high stop bit. The receiver oversamples its line input sixteen times per bit, takes any single low sample on an idle line as a possible start edge, and then confirms the start bit near its middle before it assembles the frame. Both directions share one programmable 8-bit divider that sets the oversampling rate.

For networks where many listeners share a line, an address-filter mode can be turned on. While it is on, a receiver discards every frame whose marker bit is low. The marker is the ninth bit in 9-bit mode and the sampled stop-position bit in 8-bit mode. Software reads the first frame with a high marker, decides whether the message is meant for it, and turns the filter off to take the data frames that follow. The only pin-direction output is a transmit drive enable. It stays high until a frame already in flight has finished, even when the transmitter is switched off part way through.

Top module: `sercom_uart`

## Requirements
- R1: After reset the status register (address 1) reads 0x20: bit7 receive-complete, bit6 transmit-complete, bit5 buffer-empty, bit4 framing error, bit3 overrun, bit1 received ninth bit and bit0 filter mode, with only buffer-empty set. txd is high and txd_oe is low.
- R2: The oversampling tick fires once every (divider+1) clocks, where the divider is written at address 3. One transmitted bit therefore lasts 16*(divider+1) clocks, so a frame carrying 0x00 with 8 data bits holds the line low for exactly 9*16*(divider+1) clocks.
- R3: With the transmitter enabled (control register at address 2: bit3 transmit enable, bit2 nine-bit mode, bit0 ninth transmit bit), a byte written to address 0 is sent as a low start bit, data LSB first, then the control bit0 value when nine-bit mode is on, then a high stop bit.
- R4: Buffer-empty clears when address 0 is written and sets again when the byte moves into the shift register. Transmit-complete sets when a frame ends with no byte waiting, and writing a 1 to status bit6 clears it.
- R5: Clearing transmit enable in the middle of a frame lets that frame finish intact with txd_oe held high. After it ends, txd_oe goes low and a byte written while the transmitter is disabled stays unsent (buffer-empty stays 0) until the transmitter is enabled again.
- R6: With receive enable set (control bit4), a frame on rxd is decoded from the majority of oversamples 8, 9 and 10 of each bit. The byte appears at address 0 and receive-complete sets. Reading address 0 clears receive-complete. In nine-bit mode the received ninth bit shows in status bit1.
- R7: A low pulse on an idle line that is too short to be low at the start bit's middle samples produces no character, and the receiver then accepts the next valid frame.
- R8: The framing-error flag follows the stop bit of the character held in the receive buffer: it is 1 when that sampled stop bit was low and 0 otherwise.
- R9: A character that completes while receive-complete is still set raises overrun and is dropped, leaving the buffered byte unchanged. Overrun clears on the next character that is moved into the buffer.
- R10: With filter mode on (status bit0 written 1), frames whose marker bit is 0 leave all receive status unchanged and frames whose marker is 1 are accepted. Writing status bit0 as 0 restores normal reception.
- R11: With receive enable clear, frames on rxd leave receive-complete and the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reading address 0 takes the received byte) |
| addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 divider |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| txd_oe | output | 1 | Transmit drive enable |
| dre | output | 1 | Transmit buffer empty |
| txc | output | 1 | Transmit complete |
| rxc | output | 1 | Receive complete |
| fe | output | 1 | Framing error of the buffered character |
| ovr | output | 1 | Receive overrun |

## Verification
The hardest case to reach is a transmitter switched off while the shift register is half way through a frame. The drive enable must stay up until the stop bit has gone out, and a byte written after the switch-off must stay in the buffer. The bench runs a serial decoder on txd and, in parallel with it, clears the enable about three bit times into the frame. It then checks the decoded frame, the drive enable and the still-pending buffer. Start-bit rejection is reached by driving low pulses of three and six oversample ticks, which end before the middle samples. Overrun and filtered frames are set up by sending frames back to back without reading the buffer in between.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_STAT = 2'd1,
        A_CTRL = 2'd2,
        A_BAUD = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
        logic nine;
        logic txb8;
    } ctrl_t;

    typedef struct packed {
        logic              rxc;
        logic              fe;
        logic              ovr;
        logic              b8;
        logic [BYTE_W-1:0] data;
    } rx_hold_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/sercom_baud.sv
module sercom_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= div;
        else           cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/sercom_tx.sv
module sercom_tx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          en,
    input  logic          nine,
    input  logic          full,
    input  logic [DW-1:0] data,
    input  logic          b8,
    output logic          take,
    output logic          done,
    output logic          busy,
    output logic          txd
);
    localparam int FW = DW + 3;
    localparam int PW = $clog2(OVS);
    localparam int CW = $clog2(FW + 1);

    logic [FW-1:0] sr;
    logic [PW-1:0] ph;
    logic [CW-1:0] left;
    logic bit_end, last, want;

    assign bit_end = busy && (ph == PW'(OVS - 1));
    assign last    = (left == CW'(1));
    assign want    = en && full;
    assign take    = tick && want && (!busy || (bit_end && last));
    assign done    = tick && bit_end && last && !want;
    assign txd     = busy ? sr[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '1;
            ph   <= '0;
            left <= '0;
            busy <= 1'b0;
        end else if (take) begin
            sr   <= nine ? {1'b1, b8, data, 1'b0} : {2'b11, data, 1'b0};
            ph   <= '0;
            left <= nine ? CW'(FW) : CW'(FW - 1);
            busy <= 1'b1;
        end else if (tick && busy) begin
            if (bit_end) begin
                ph <= '0;
                if (last) begin
                    busy <= 1'b0;
                end else begin
                    sr   <= {1'b1, sr[FW-1:1]};
                    left <= left - 1'b1;
                end
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
    import sercom_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          en,
    input  logic          nine,
    input  logic          rxd,
    output logic          fvalid,
    output logic [DW-1:0] fdata,
    output logic          fb8,
    output logic          fstop
);
    localparam int SW  = $clog2(OVS + 1);
    localparam int MID = OVS / 2;
    localparam int CW  = $clog2(DW + 2);

    rx_state_e     st;
    logic [SW-1:0] s;
    logic          sa, sb;
    logic [DW:0]   sh;
    logic [CW-1:0] idx;
    logic          vote, at_vote;
    logic [CW-1:0] stop_idx;

    assign vote     = maj3(sa, sb, rxd);
    assign at_vote  = (s == SW'(MID + 2));
    assign stop_idx = nine ? CW'(DW + 1) : CW'(DW);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RX_IDLE;
            s      <= '0;
            sa     <= 1'b1;
            sb     <= 1'b1;
            sh     <= '0;
            idx    <= '0;
            fvalid <= 1'b0;
            fdata  <= '0;
            fb8    <= 1'b0;
            fstop  <= 1'b1;
        end else begin
            fvalid <= 1'b0;
            if (!en) begin
                st <= RX_IDLE;
            end else if (tick) begin
                if (st == RX_IDLE) begin
                    if (!rxd) begin
                        st <= RX_START;
                        s  <= SW'(1);
                    end
                end else begin
                    s <= (s == SW'(OVS)) ? SW'(1) : s + 1'b1;
                    if (s == SW'(MID))     sa <= rxd;
                    if (s == SW'(MID + 1)) sb <= rxd;
                    if (at_vote) begin
                        if (st == RX_START) begin
                            if (vote) begin
                                st <= RX_IDLE;
                            end else begin
                                st  <= RX_BITS;
                                idx <= '0;
                            end
                        end else if (idx == stop_idx) begin
                            st     <= RX_IDLE;
                            fvalid <= 1'b1;
                            fstop  <= vote;
                            fdata  <= nine ? sh[DW-1:0] : sh[DW:1];
                            fb8    <= nine & sh[DW];
                        end else begin
                            sh  <= {vote, sh[DW:1]};
                            idx <= idx + 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sercom_uart.sv
module sercom_uart
    import sercom_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       txd_oe,
    output logic       dre,
    output logic       txc,
    output logic       rxc,
    output logic       fe,
    output logic       ovr
);
    localparam int DW = BYTE_W;

    reg_addr_e        sel;
    ctrl_t            ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic [DW-1:0]    tx_buf;
    logic             dre_q, txc_q, mp_q;
    rx_hold_t         hold_q;
    logic [1:0]       sync_q;

    logic baud_tick, tx_take, tx_done, tx_busy;
    logic fvalid, fb8, fstop, marker, accept, pop;
    logic [DW-1:0] fdata;

    assign sel = reg_addr_e'(addr);
    assign pop = rd_en && (sel == A_DATA);

    sercom_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .div(div_q), .tick(baud_tick)
    );

    sercom_tx #(.DW(DW), .OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .tick(baud_tick), .en(ctrl_q.tx_en),
        .nine(ctrl_q.nine), .full(!dre_q), .data(tx_buf), .b8(ctrl_q.txb8),
        .take(tx_take), .done(tx_done), .busy(tx_busy), .txd(txd)
    );

    sercom_rx #(.DW(DW), .OVS(OVS)) u_rx (
        .clk(clk), .rst(rst), .tick(baud_tick), .en(ctrl_q.rx_en),
        .nine(ctrl_q.nine), .rxd(sync_q[1]), .fvalid(fvalid),
        .fdata(fdata), .fb8(fb8), .fstop(fstop)
    );

    // address marker: ninth bit when present, else the stop-position bit
    assign marker = ctrl_q.nine ? fb8 : fstop;
    assign accept = fvalid && (!mp_q || marker);

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end

    // control, divider and filter mode
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
            mp_q   <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                A_CTRL: ctrl_q <= '{rx_en: wdata[4], tx_en: wdata[3],
                                    nine: wdata[2], txb8: wdata[0]};
                A_BAUD: div_q  <= DIV_W'(wdata);
                A_STAT: mp_q   <= wdata[0];
                default: ;
            endcase
        end
    end

    // transmit buffer and status
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf <= '0;
            dre_q  <= 1'b1;
            txc_q  <= 1'b0;
        end else begin
            if (wr_en && sel == A_DATA) begin
                tx_buf <= wdata;
                dre_q  <= 1'b0;
            end else if (tx_take) begin
                dre_q  <= 1'b1;
            end
            if (wr_en && sel == A_STAT && wdata[6]) txc_q <= 1'b0;
            else if (tx_done)                       txc_q <= 1'b1;
            else if (tx_take)                       txc_q <= 1'b0;
        end
    end

    // receive buffer and status
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            if (pop) hold_q.rxc <= 1'b0;
            if (accept) begin
                if (hold_q.rxc && !pop) begin
                    hold_q.ovr <= 1'b1;
                end else begin
                    hold_q.data <= fdata;
                    hold_q.b8   <= fb8;
                    hold_q.fe   <= !fstop;
                    hold_q.ovr  <= 1'b0;
                    hold_q.rxc  <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (sel)
            A_DATA:  rdata = hold_q.data;
            A_STAT:  rdata = {hold_q.rxc, txc_q, dre_q, hold_q.fe, hold_q.ovr,
                              1'b0, hold_q.b8, mp_q};
            A_CTRL:  rdata = {3'b000, ctrl_q.rx_en, ctrl_q.tx_en, ctrl_q.nine,
                              1'b0, ctrl_q.txb8};
            default: rdata = 8'(div_q);
        endcase
    end

    assign txd_oe = ctrl_q.tx_en | tx_busy;
    assign dre    = dre_q;
    assign txc    = txc_q;
    assign rxc    = hold_q.rxc;
    assign fe     = hold_q.fe;
    assign ovr    = hold_q.ovr;
endmodule

// File: rtl/sercom_uart_chk.sv
module sercom_uart_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             txd,
    input logic             txd_oe,
    input logic             txc,
    input logic             rxc,
    input logic             ovr,
    input logic             tick,
    input logic             tx_en,
    input logic             tx_busy,
    input logic [DIV_W-1:0] div
);
    // R1
    line_idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !txd_oe |-> txd);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (div != '0 && tick) |=> !tick);

    // R4
    txc_on_idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(txc) |-> (txd && !tx_busy));

    // R5
    oe_drop_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(txd_oe) |-> (txd && !tx_en));

    // R9
    ovr_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> rxc);
endmodule

bind sercom_uart sercom_uart_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .txd(txd), .txd_oe(txd_oe), .txc(txc),
    .rxc(rxc), .ovr(ovr), .tick(baud_tick), .tx_en(ctrl_q.tx_en),
    .tx_busy(tx_busy), .div(div_q)
);

// File: tb/sercom_uart_tb.sv
module sercom_uart_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       rxd_drv = 1'b1, loop = 1'b0;
    logic       rxd, txd, txd_oe, dre, txc, rxc, fe, ovr;

    int n_chk = 0, n_fail = 0, bp = 16, cyc = 0;

    assign rxd = loop ? txd : rxd_drv;

    sercom_uart u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .txd_oe(txd_oe),
        .dre(dre), .txc(txc), .rxc(rxc), .fe(fe), .ovr(ovr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] stat_of(bit rc, bit tc, bit de, bit fr, bit ov, bit b8, bit mp);
        return {rc, tc, de, fr, ov, 1'b0, b8, mp};
    endfunction

    function automatic logic [7:0] ctrl_of(bit re, bit te, bit nn, bit b8);
        return {3'b000, re, te, nn, 1'b0, b8};
    endfunction

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_baud(input int div);
        wreg(2'd3, 8'(div));
        bp = 16 * (div + 1);
        idle(600);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b8, input logic sp, input bit nine);
        @(negedge clk);
        rxd_drv = 1'b0; idle(bp);
        for (int i = 0; i < 8; i++) begin rxd_drv = d[i]; idle(bp); end
        if (nine) begin rxd_drv = b8; idle(bp); end
        rxd_drv = sp; idle(bp);
        rxd_drv = 1'b1; idle(bp);
    endtask

    task automatic grab_tx(input bit nine, output logic [7:0] d, output logic b8,
                           output logic st0, output logic sp);
        do @(negedge clk); while (txd !== 1'b0);
        idle(bp / 2);
        st0 = txd;
        for (int i = 0; i < 8; i++) begin idle(bp); d[i] = txd; end
        b8 = 1'b0;
        if (nine) begin idle(bp); b8 = txd; end
        idle(bp);
        sp = txd;
    endtask

    task automatic wait_txc();
        int n = 0;
        while (!txc && n < 40 * bp) begin @(negedge clk); n++; end
        check_eq("R4 txc reached", int'(txc), 1);
        wreg(2'd1, 8'h40);
    endtask

    task automatic wait_rxc();
        int n = 0;
        while (!rxc && n < 40 * bp) begin @(negedge clk); n++; end
    endtask

    initial begin
        logic [7:0] v, d, r;
        logic b8, st0, sp, nb;
        int w;
        void'($urandom(32'h5EC0_0A11));

        idle(5);
        rst = 1'b0;
        idle(2);
        // R1 reset state
        rreg(2'd1, v);
        check_eq("R1 status", v, stat_of(0, 0, 1, 0, 0, 0, 0));
        check_eq("R1 txd", int'(txd), 1);
        check_eq("R1 txd_oe", int'(txd_oe), 0);

        // R2 bit length at two divider values
        set_baud(5);
        wreg(2'd2, ctrl_of(0, 1, 0, 0));
        wreg(2'd0, 8'h00);
        do @(negedge clk); while (txd !== 1'b0);
        w = 0;
        while (txd === 1'b0 && w < 5000) begin @(negedge clk); w++; end
        check_eq("R2 low width div5", w, 9 * bp);
        wait_txc();
        set_baud(2);
        wreg(2'd0, 8'h00);
        do @(negedge clk); while (txd !== 1'b0);
        w = 0;
        while (txd === 1'b0 && w < 5000) begin @(negedge clk); w++; end
        check_eq("R2 low width div2", w, 9 * bp);
        wait_txc();
        set_baud(3);

        // R3 frame format, random data and modes
        for (int k = 0; k < 6; k++) begin
            nb = 1'($urandom);
            b8 = 1'($urandom);
            d  = 8'($urandom);
            if (k == 0) begin nb = 1'b1; b8 = 1'b1; d = 8'h80; end
            if (k == 1) begin nb = 1'b0; d = 8'h01; end
            wreg(2'd2, ctrl_of(0, 1, nb, b8));
            wreg(2'd0, d);
            grab_tx(nb, v, r[0], st0, sp);
            check_eq("R3 start bit", int'(st0), 0);
            check_eq("R3 data", v, d);
            if (nb) check_eq("R3 ninth bit", int'(r[0]), int'(b8));
            check_eq("R3 stop bit", int'(sp), 1);
            wait_txc();
        end

        // R4 buffer-empty and transmit-complete
        wreg(2'd2, ctrl_of(0, 1, 0, 0));
        wreg(2'd0, 8'h3C);
        idle(12);
        wreg(2'd0, 8'hC3);
        idle(3 * bp);
        rreg(2'd1, v);
        check_eq("R4 status mid-frame", v, stat_of(0, 0, 0, 0, 0, 0, 0));
        w = 0;
        while (!txc && w < 40 * bp) begin @(negedge clk); w++; end
        rreg(2'd1, v);
        check_eq("R4 status after both", v, stat_of(0, 1, 1, 0, 0, 0, 0));
        wreg(2'd1, 8'h40);
        rreg(2'd1, v);
        check_eq("R4 txc cleared", v, stat_of(0, 0, 1, 0, 0, 0, 0));

        // R5 disable during a frame
        wreg(2'd0, 8'hA5);
        fork
            grab_tx(1'b0, v, b8, st0, sp);
            begin
                idle(3 * bp);
                wreg(2'd2, ctrl_of(0, 0, 0, 0));
                idle(1);
                check_eq("R5 oe held mid-frame", int'(txd_oe), 1);
            end
        join
        check_eq("R5 data intact", v, 8'hA5);
        check_eq("R5 stop intact", int'(sp), 1);
        idle(bp);
        check_eq("R5 oe dropped", int'(txd_oe), 0);
        wreg(2'd1, 8'h40);
        wreg(2'd0, 8'h11);
        idle(12 * bp);
        check_eq("R5 byte held", int'(dre), 0);
        check_eq("R5 line idle", int'(txd), 1);
        wreg(2'd2, ctrl_of(0, 1, 0, 0));
        grab_tx(1'b0, v, b8, st0, sp);
        check_eq("R5 held byte sent", v, 8'h11);
        wait_txc();
        wreg(2'd2, ctrl_of(0, 0, 0, 0));

        // R6 reception, random data and modes
        for (int k = 0; k < 8; k++) begin
            nb = 1'($urandom);
            b8 = 1'($urandom);
            d  = 8'($urandom);
            wreg(2'd2, ctrl_of(1, 0, nb, 0));
            send_frame(d, b8, 1'b1, nb);
            rreg(2'd1, v);
            check_eq("R6 status", v, stat_of(1, 0, 1, 0, 0, b8 & nb, 0));
            rreg(2'd0, v);
            check_eq("R6 data", v, d);
            check_eq("R6 rxc cleared", int'(rxc), 0);
        end

        // R7 short low pulses rejected
        wreg(2'd2, ctrl_of(1, 0, 0, 0));
        @(negedge clk); rxd_drv = 1'b0; idle(3 * bp / 16); rxd_drv = 1'b1;
        idle(12 * bp);
        check_eq("R7 3-tick pulse", int'(rxc), 0);
        @(negedge clk); rxd_drv = 1'b0; idle(6 * bp / 16); rxd_drv = 1'b1;
        idle(12 * bp);
        check_eq("R7 6-tick pulse", int'(rxc), 0);
        send_frame(8'h96, 1'b0, 1'b1, 1'b0);
        rreg(2'd0, v);
        check_eq("R7 recovery data", v, 8'h96);

        // R8 framing error follows buffered stop bit
        send_frame(8'h5E, 1'b0, 1'b0, 1'b0);
        idle(bp);
        rreg(2'd1, v);
        check_eq("R8 fe set", v, stat_of(1, 0, 1, 1, 0, 0, 0));
        rreg(2'd0, v);
        check_eq("R8 data with bad stop", v, 8'h5E);
        send_frame(8'h21, 1'b0, 1'b1, 1'b0);
        rreg(2'd1, v);
        check_eq("R8 fe cleared", v, stat_of(1, 0, 1, 0, 0, 0, 0));
        rreg(2'd0, v);

        // R9 overrun
        send_frame(8'hA1, 1'b0, 1'b1, 1'b0);
        send_frame(8'hB2, 1'b0, 1'b1, 1'b0);
        rreg(2'd1, v);
        check_eq("R9 ovr set", v, stat_of(1, 0, 1, 0, 1, 0, 0));
        rreg(2'd0, v);
        check_eq("R9 first byte kept", v, 8'hA1);
        rreg(2'd1, v);
        check_eq("R9 ovr persists", v, stat_of(0, 0, 1, 0, 1, 0, 0));
        send_frame(8'hC3, 1'b0, 1'b1, 1'b0);
        rreg(2'd1, v);
        check_eq("R9 ovr cleared", v, stat_of(1, 0, 1, 0, 0, 0, 0));
        rreg(2'd0, v);
        check_eq("R9 new byte", v, 8'hC3);

        // R10 address filter
        wreg(2'd2, ctrl_of(1, 0, 1, 0));
        wreg(2'd1, 8'h01);
        send_frame(8'h33, 1'b0, 1'b1, 1'b1);
        rreg(2'd1, v);
        check_eq("R10 data frame ignored", v, stat_of(0, 0, 1, 0, 0, 0, 1));
        send_frame(8'h5A, 1'b1, 1'b1, 1'b1);
        rreg(2'd1, v);
        check_eq("R10 address accepted", v, stat_of(1, 0, 1, 0, 0, 1, 1));
        rreg(2'd0, v);
        check_eq("R10 address byte", v, 8'h5A);
        wreg(2'd1, 8'h00);
        send_frame(8'h44, 1'b0, 1'b1, 1'b1);
        rreg(2'd1, v);
        check_eq("R10 filter off", v, stat_of(1, 0, 1, 0, 0, 0, 0));
        rreg(2'd0, v);
        check_eq("R10 data byte", v, 8'h44);

        // R11 receiver disabled
        wreg(2'd2, ctrl_of(0, 0, 0, 0));
        send_frame(8'h7E, 1'b0, 1'b1, 1'b0);
        rreg(2'd1, v);
        check_eq("R11 no reception", v, stat_of(0, 0, 1, 0, 0, 0, 0));
        rreg(2'd0, v);
        check_eq("R11 buffer kept", v, 8'h44);

        // R3 R6 random loopback
        loop = 1'b1;
        for (int k = 0; k < 20; k++) begin
            nb = 1'($urandom);
            b8 = 1'($urandom);
            d  = 8'($urandom);
            wreg(2'd2, ctrl_of(1, 1, nb, b8));
            wreg(2'd0, d);
            wait_rxc();
            rreg(2'd1, v);
            check_eq("R6 loopback status", v & 8'h9B, stat_of(1, 0, 0, 0, 0, b8 & nb, 0));
            rreg(2'd0, v);
            check_eq("R3 loopback data", v, d);
            wait_txc();
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule